// File: doc/BRIEF.md
# I2C Arbitrating Master

This block is the transmit side of an I2C master that shares its bus with other masters. It drives the bus through two open-drain lines. Each line has a drive-low enable, and the block also samples the resolved level of each line. The block issues START, repeated START, STOP and acknowledge conditions on one-cycle command strobes. It shifts a byte, most significant bit first, out of a transmit port that uses a valid/ready handshake. The ninth clock of every byte leaves SDA released for the slave's answer.

Arbitration is continuous. At the middle of every SCL-high period in which the block has released SDA, it compares that release with the synchronized SDA level. If it wanted a '1' and finds a '0', another master owns the bus. The block then drops whatever it was doing, lets go of both lines and raises a sticky collision flag. It keeps watching the bus afterwards. START and STOP conditions seen on the lines update two status bits, and a STOP raises the general event flag, so software can tell when the bus is free again.

The transmit port uses a valid/ready handshake with back-pressure. A byte is taken on a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is low while a sequence or byte is in progress, while the collision flag is set, and in any cycle that carries a command strobe. The source keeps `tx_data` steady until the byte is accepted.

Top module: `i2c_arb_master`

## Requirements
- R1: After reset, both drive enables are low, `busy`, `buf_full`, `coll_flag`, `event_flag`, `bus_start` and `bus_stop` are low, and `tx_ready` is high.
- R2: A START strobe on a free bus makes SDA fall while SCL is high and then pulls SCL low. Once the sequence ends, both lines stay driven low, `bus_start` is high and `event_flag` is set.
- R3: An accepted byte is sent most significant bit first over nine SCL pulses, and SDA is released on the ninth. The master changes SDA only while SCL is low. `buf_full` rises on acceptance and clears when the ninth pulse ends, after which SCL stays low and SDA stays released.
- R4: If the master has released SDA for a data bit and the synchronized SDA is low at the midpoint of SCL high, it sets `coll_flag`. It also halts the byte after that pulse, clears `buf_full`, releases both lines and returns to idle.
- R5: A collision during a STOP, repeated START, START or acknowledge sequence aborts that sequence, releases both lines and drops `busy`.
- R6: After a collision, the next accepted byte is sent in full, starting from its most significant bit.
- R7: After a collision the bus monitor keeps running. A STOP on the lines (SDA rising while SCL is high) sets `event_flag`.
- R8: A detected START sets `bus_start` and clears `bus_stop`. A detected STOP does the opposite. Both read 0 after reset, and they are never high together.
- R9: The bus is free when `bus_stop` is high or when both status bits are low. A START strobe on a bus that is not free is refused: `coll_flag` is set, `busy` stays low and neither drive enable changes.
- R10: `coll_flag` stays set until a `coll_clr` strobe. While it is set, all command strobes are ignored and `tx_ready` is low.
- R11: Command strobes that arrive while a sequence or byte is in progress are ignored.
- R12: An acknowledge strobe produces one SCL pulse with SDA driven low if `ack_nack` is 0, or released if it is 1. A repeated START strobe produces a new START condition on the lines. A STOP strobe makes SDA rise while SCL is high and leaves both lines released.
- R13: `event_flag` is set whenever a sequence or byte completes. It holds until an `event_clr` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Resolved SCL level |
| sda_i | input | 1 | Resolved SDA level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | DW | Transmit byte |
| tx_ready | output | 1 | Transmit byte can be accepted |
| cmd_start | input | 1 | START strobe (highest priority) |
| cmd_rstart | input | 1 | Repeated START strobe |
| cmd_stop | input | 1 | STOP strobe |
| cmd_ack | input | 1 | Acknowledge strobe (lowest command priority) |
| ack_nack | input | 1 | Level sent by the acknowledge strobe |
| coll_clr | input | 1 | Clear strobe for `coll_flag` |
| event_clr | input | 1 | Clear strobe for `event_flag` |
| busy | output | 1 | Sequence or byte in progress |
| buf_full | output | 1 | Accepted byte not yet fully sent |
| coll_flag | output | 1 | Sticky bus collision flag |
| event_flag | output | 1 | Sticky serial event flag |
| bus_start | output | 1 | Last bus condition seen was a START |
| bus_stop | output | 1 | Last bus condition seen was a STOP |

## Verification
The properties assume the following about the lines. Each line is the wired-AND of this block's enable and one other agent. No agent stretches SCL. The other agent changes SDA while SCL is high only to form a STOP. The bench models exactly this bus. The second master pulls SDA low only from the start of a chosen bit's low phase. It lets go either at the next SCL fall or after the block has released SCL, which produces a genuine STOP. Collision cases are chosen at random bit positions against random bytes, and each byte's own value decides whether the collision should occur.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_RSTART,
    ST_STOP,
    ST_ACK,
    ST_DATA
  } seq_e;

  // line plan for one quarter-bit step
  typedef struct packed {
    logic scl_rel;  // 1: SCL released
    logic sda_rel;  // 1: SDA released
    logic chk;      // compare SDA at the end of this step
    logic last;     // final step of the sequence
  } step_t;

endpackage

// File: rtl/i2cm_line_mon.sv
module i2cm_line_mon #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic stop_det,
  output logic bus_start,
  output logic bus_stop
);
  logic [SYNC-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;
  logic start_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC-2:0], sda_i};
      scl_q  <= scl_ff[SYNC-1];
      sda_q  <= sda_ff[SYNC-1];
    end
  end

  assign scl_s     = scl_ff[SYNC-1];
  assign sda_s     = sda_ff[SYNC-1];
  assign start_det = scl_s && scl_q && sda_q && !sda_s;
  assign stop_det  = scl_s && scl_q && !sda_q && sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_start <= 1'b0;
      bus_stop  <= 1'b0;
    end else if (start_det) begin
      bus_start <= 1'b1;
      bus_stop  <= 1'b0;
    end else if (stop_det) begin
      bus_start <= 1'b0;
      bus_stop  <= 1'b1;
    end
  end
endmodule

// File: rtl/i2cm_step_rom.sv
module i2cm_step_rom
  import i2cm_pkg::*;
(
  input  seq_e       st,
  input  logic [1:0] step,
  input  logic       data_bit,
  input  logic       last_bit,
  input  logic       ack_bit,
  output step_t      s
);
  logic v;
  logic is_data;

  always_comb begin
    is_data = (st == ST_DATA);
    v = (st == ST_ACK) ? ack_bit : (last_bit ? 1'b1 : data_bit);
    s = '{1'b1, 1'b1, 1'b0, 1'b0};
    case (st)
      ST_START: begin
        case (step)
          2'd0:    s = '{1'b1, 1'b1, 1'b1, 1'b0};
          2'd1:    s = '{1'b1, 1'b0, 1'b0, 1'b0};
          default: s = '{1'b0, 1'b0, 1'b0, 1'b1};
        endcase
      end
      ST_RSTART: begin
        case (step)
          2'd0:    s = '{1'b0, 1'b1, 1'b0, 1'b0};
          2'd1:    s = '{1'b1, 1'b1, 1'b1, 1'b0};
          2'd2:    s = '{1'b1, 1'b0, 1'b0, 1'b0};
          default: s = '{1'b0, 1'b0, 1'b0, 1'b1};
        endcase
      end
      ST_STOP: begin
        case (step)
          2'd0:    s = '{1'b0, 1'b0, 1'b0, 1'b0};
          2'd1:    s = '{1'b1, 1'b0, 1'b0, 1'b0};
          default: s = '{1'b1, 1'b1, 1'b1, 1'b1};
        endcase
      end
      ST_ACK, ST_DATA: begin
        s.scl_rel = (step == 2'd1) || (step == 2'd2);
        s.sda_rel = v;
        s.chk     = v && (step == 2'd1) && !(is_data && last_bit);
        s.last    = (step == 2'd3) && (!is_data || last_bit);
      end
      default: s = '{1'b1, 1'b1, 1'b0, 1'b0};
    endcase
  end
endmodule

// File: rtl/i2cm_sticky.sv
module i2cm_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/i2c_arb_master.sv
module i2c_arb_master
  import i2cm_pkg::*;
#(
  parameter int QTR = 4,  // clocks per quarter bit, at least 4
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  output logic          tx_ready,
  input  logic          cmd_start,
  input  logic          cmd_rstart,
  input  logic          cmd_stop,
  input  logic          cmd_ack,
  input  logic          ack_nack,
  input  logic          coll_clr,
  input  logic          event_clr,
  output logic          busy,
  output logic          buf_full,
  output logic          coll_flag,
  output logic          event_flag,
  output logic          bus_start,
  output logic          bus_stop
);
  localparam int QW = (QTR > 1) ? $clog2(QTR) : 1;
  localparam int BW = $clog2(DW + 2);

  seq_e          st;
  logic [QW-1:0] qcnt;
  logic [1:0]    step;
  logic [BW-1:0] bitn;
  logic [DW-1:0] shreg;
  logic          ack_q, hold_scl_rel, hold_sda_rel, buf_full_q;
  logic          scl_s, sda_s, stop_det;
  step_t         cur;

  i2cm_line_mon #(.SYNC(2)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .stop_det(stop_det),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  i2cm_step_rom u_rom (
    .st(st), .step(step), .data_bit(shreg[DW-1]),
    .last_bit(bitn == BW'(DW)), .ack_bit(ack_q), .s(cur)
  );

  logic step_end, coll_hit, any_cmd, cmd_ok, bus_free, refuse, done;

  assign step_end = (st != ST_IDLE) && (qcnt == QW'(QTR - 1));
  assign coll_hit = step_end && cur.chk && scl_s && !sda_s;
  assign any_cmd  = cmd_start || cmd_rstart || cmd_stop || cmd_ack;
  assign cmd_ok   = (st == ST_IDLE) && !coll_flag;
  assign bus_free = bus_stop || (!bus_start && !bus_stop);
  assign refuse   = cmd_ok && cmd_start && !bus_free;
  assign done     = step_end && cur.last && !coll_hit;
  assign tx_ready = cmd_ok && !any_cmd;

  i2cm_sticky u_coll (
    .clk(clk), .rst_n(rst_n), .set(coll_hit || refuse), .clr(coll_clr), .q(coll_flag)
  );
  i2cm_sticky u_evt (
    .clk(clk), .rst_n(rst_n), .set(done || stop_det), .clr(event_clr), .q(event_flag)
  );

  assign scl_oe   = (st == ST_IDLE) ? !hold_scl_rel : !cur.scl_rel;
  assign sda_oe   = (st == ST_IDLE) ? !hold_sda_rel : !cur.sda_rel;
  assign busy     = (st != ST_IDLE);
  assign buf_full = buf_full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      qcnt         <= '0;
      step         <= '0;
      bitn         <= '0;
      shreg        <= '0;
      ack_q        <= 1'b0;
      hold_scl_rel <= 1'b1;
      hold_sda_rel <= 1'b1;
      buf_full_q   <= 1'b0;
    end else if (coll_hit) begin
      st           <= ST_IDLE;
      qcnt         <= '0;
      step         <= '0;
      bitn         <= '0;
      hold_scl_rel <= 1'b1;
      hold_sda_rel <= 1'b1;
      buf_full_q   <= 1'b0;
    end else if (st != ST_IDLE) begin
      if (!step_end) begin
        qcnt <= qcnt + 1'b1;
      end else begin
        qcnt <= '0;
        if (cur.last) begin
          st           <= ST_IDLE;
          step         <= '0;
          bitn         <= '0;
          buf_full_q   <= 1'b0;
          hold_scl_rel <= cur.scl_rel;
          hold_sda_rel <= cur.sda_rel;
        end else if (st == ST_DATA && step == 2'd3) begin
          step  <= '0;
          bitn  <= bitn + 1'b1;
          shreg <= {shreg[DW-2:0], 1'b0};
        end else begin
          step <= step + 1'b1;
        end
      end
    end else if (cmd_ok) begin
      if (cmd_start) begin
        if (bus_free) st <= ST_START;
      end else if (cmd_rstart) begin
        st <= ST_RSTART;
      end else if (cmd_stop) begin
        st <= ST_STOP;
      end else if (cmd_ack) begin
        st    <= ST_ACK;
        ack_q <= ack_nack;
      end else if (tx_valid) begin
        st         <= ST_DATA;
        shreg      <= tx_data;
        bitn       <= '0;
        buf_full_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_arb_master_chk.sv
module i2c_arb_master_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic sda_oe,
  input logic tx_valid,
  input logic tx_ready,
  input logic busy,
  input logic buf_full,
  input logic coll_flag,
  input logic coll_clr,
  input logic event_flag,
  input logic event_clr,
  input logic bus_start,
  input logic bus_stop
);
  // R8
  bus_flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_start && bus_stop));

  // R3
  data_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && $past(buf_full) && (sda_oe != $past(sda_oe))) |-> (scl_oe && $past(scl_oe)));

  // R3
  accept_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_full) |-> $past(tx_valid && tx_ready));

  // R4
  coll_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(coll_flag) && $past(busy)) |-> (!busy && !scl_oe && !sda_oe && !buf_full));

  // R9
  refuse_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(coll_flag) && !$past(busy)) |-> (!busy && $stable(scl_oe) && $stable(sda_oe)));

  // R10
  ignore_when_coll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_flag && !busy) |=> !busy);

  // R10
  coll_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(coll_flag) |-> $past(coll_clr));

  // R13
  event_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(event_flag) |-> $past(event_clr));
endmodule

bind i2c_arb_master i2c_arb_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .busy(busy), .buf_full(buf_full),
  .coll_flag(coll_flag), .coll_clr(coll_clr), .event_flag(event_flag),
  .event_clr(event_clr), .bus_start(bus_start), .bus_stop(bus_stop)
);

// File: tb/i2c_arb_master_test.sv
module i2c_arb_master_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic scl_oe, sda_oe, tx_ready, busy, buf_full, coll_flag, event_flag, bus_start, bus_stop;
  logic tx_valid = 0, cmd_start = 0, cmd_rstart = 0, cmd_stop = 0, cmd_ack = 0;
  logic ack_nack = 0, coll_clr = 0, event_clr = 0;
  logic [7:0] tx_data = 8'h00;
  logic other_sda = 1'b0;  // 1: second master pulls SDA low

  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || other_sda);

  i2c_arb_master #(.QTR(4), .DW(8)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .cmd_start(cmd_start), .cmd_rstart(cmd_rstart),
    .cmd_stop(cmd_stop), .cmd_ack(cmd_ack), .ack_nack(ack_nack),
    .coll_clr(coll_clr), .event_clr(event_clr), .busy(busy), .buf_full(buf_full),
    .coll_flag(coll_flag), .event_flag(event_flag), .bus_start(bus_start),
    .bus_stop(bus_stop)
  );

  // line-level monitor
  logic [15:0] cap = '0;
  int ncap = 0, nfall = 0, nstart = 0, nstop = 0;
  logic pscl = 1'b1, psda = 1'b1;
  always @(negedge clk) begin
    if (!pscl && scl_line) begin cap = {cap[14:0], sda_line}; ncap++; end
    if (pscl && !scl_line) nfall++;
    if (pscl && scl_line && psda && !sda_line) nstart++;
    if (pscl && scl_line && !psda && sda_line) nstop++;
    pscl = scl_line;
    psda = sda_line;
  end

  int total = 0, bad = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_coll(input logic [7:0] d, input int k, input bit inj);
    return inj && d[7-k];
  endfunction

  function automatic logic [8:0] exp_frame(input logic [7:0] d);
    return {d, 1'b1};
  endfunction

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic pulse(input int which);
    tick();
    case (which)
      0: cmd_start = 1;  1: cmd_rstart = 1;  2: cmd_stop = 1;
      3: cmd_ack = 1;    4: coll_clr = 1;    default: event_clr = 1;
    endcase
    tick();
    cmd_start = 0; cmd_rstart = 0; cmd_stop = 0; cmd_ack = 0; coll_clr = 0; event_clr = 0;
  endtask

  task automatic wait_idle(input string req);
    int t = 0;
    while (busy && t < 5000) begin tick(); t++; end
    chk(req, "sequence finished", busy, 0);
  endtask

  task automatic do_start();
    int s0 = nstart;
    pulse(0);
    wait_idle("R2");
    chk("R2", "START on lines", nstart - s0, 1);
    chk("R2", "bus_start", bus_start, 1);
    chk("R8", "bus_stop after START", bus_stop, 0);
    chk("R2", "SCL held low", scl_oe, 1);
  endtask

  task automatic send_byte(input logic [7:0] d, input int k, input bit inj, input bit poke, output bit col);
    int bc = ncap; int bf = nfall; int sb = nstop; int t = 0; bit e;
    pulse(5);
    tick();
    tx_data = d; tx_valid = 1;
    chk("R3", "tx_ready before write", tx_ready, 1);
    if (inj && k == 0) other_sda = 1;
    tick();
    tx_valid = 0;
    chk("R3", "buf_full after accept", buf_full, 1);
    chk("R3", "tx_ready while busy", tx_ready, 0);
    while (busy && t < 5000) begin
      tick(); t++;
      cmd_stop = poke && (t == 12);  // R11 strobe mid-byte
      if (inj && k > 0 && nfall - bf == k) other_sda = 1;
      if (inj && nfall - bf == k + 1) other_sda = 0;
    end
    cmd_stop = 0;
    e = exp_coll(d, k, inj);
    chk("R4", "collision outcome", coll_flag, e);
    chk("R4", "buf_full after byte", buf_full, 0);
    if (e) begin
      chk("R4", "SCL released", scl_oe, 0);
      chk("R4", "SDA released", sda_oe, 0);
      chk("R4", "halted after bit", ncap - bc, k + 1);
    end else begin
      chk("R3", "nine pulses", ncap - bc, 9);
      chk("R6", "frame from MSB", cap[8:0], exp_frame(d));
      chk("R13", "event after byte", event_flag, 1);
      chk("R11", "no STOP from mid-byte strobe", nstop - sb, 0);
    end
    col = e;
  endtask

  task automatic recover();
    pulse(5);
    chk("R13", "event cleared", event_flag, 0);
    tick();
    other_sda = 0;
    repeat (6) tick();
    chk("R7", "STOP after collision sets event", event_flag, 1);
    chk("R8", "bus_stop after STOP", bus_stop, 1);
    chk("R10", "flag still set", coll_flag, 1);
    pulse(4);
    chk("R10", "flag cleared", coll_flag, 0);
    do_start();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit col;
    logic [7:0] d;
    int k, s0, c0;
    void'($urandom(32'd20231));
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1
    chk("R1", "scl_oe", scl_oe, 0);
    chk("R1", "sda_oe", sda_oe, 0);
    chk("R1", "flags", {busy, buf_full, coll_flag, event_flag, bus_start, bus_stop}, 0);
    chk("R1", "tx_ready", tx_ready, 1);

    do_start();
    chk("R2", "event after START", event_flag, 1);
    chk("R2", "SDA held low", sda_oe, 1);

    for (int i = 0; i < 6; i++) begin
      d = 8'($urandom);
      send_byte(d, 0, 0, (i == 2), col);
    end

    // R12 acknowledge levels
    c0 = ncap; ack_nack = 0; pulse(3); wait_idle("R12");
    chk("R12", "ack pulse count", ncap - c0, 1);
    chk("R12", "ack low", cap[0], 0);
    c0 = ncap; ack_nack = 1; pulse(3); wait_idle("R12");
    chk("R12", "nack released", cap[0], 1);

    // R12 repeated START
    s0 = nstart; pulse(5); pulse(1); wait_idle("R12");
    chk("R12", "repeated START seen", nstart - s0, 1);
    chk("R13", "event after repeated START", event_flag, 1);

    // R9 refused START on busy bus
    pulse(0);
    chk("R9", "refusal flag", coll_flag, 1);
    chk("R9", "no sequence", busy, 0);
    chk("R9", "lines kept", {scl_oe, sda_oe}, 2'b11);

    // R10 commands ignored while flag set
    s0 = nstop; pulse(2);
    repeat (20) tick();
    chk("R10", "stop ignored", nstop - s0, 0);
    chk("R10", "idle", busy, 0);
    chk("R10", "tx_ready low", tx_ready, 0);
    pulse(4);
    chk("R10", "cleared", {coll_flag, tx_ready}, 2'b01);

    // R12 STOP
    s0 = nstop; pulse(2); wait_idle("R12");
    chk("R12", "STOP on lines", nstop - s0, 1);
    chk("R8", "status after STOP", {bus_start, bus_stop}, 2'b01);
    chk("R12", "lines released", {scl_oe, sda_oe}, 2'b00);

    do_start();  // R9 bus free after STOP

    // R4 / R6 collisions during data
    for (int i = 0; i < 10; i++) begin
      if (i == 0) begin d = 8'hFF; k = 3; end
      else if (i == 1) begin d = 8'h00; k = 5; end
      else begin d = 8'($urandom); k = int'($urandom % 8); end
      send_byte(d, k, 1, 0, col);
      if (col) begin
        recover();
        d = 8'($urandom);
        send_byte(d, 0, 0, 0, col);  // R6 full byte after collision
      end
    end

    // R5 collision during STOP
    tick(); other_sda = 1;
    pulse(2); wait_idle("R5");
    chk("R5", "STOP aborted", coll_flag, 1);
    chk("R5", "lines released", {scl_oe, sda_oe}, 2'b00);
    recover();

    // R5 collision during acknowledge with released level
    tick(); other_sda = 1; ack_nack = 1;
    pulse(3); wait_idle("R5");
    chk("R5", "ack aborted", coll_flag, 1);
    chk("R5", "lines released", {scl_oe, sda_oe}, 2'b00);
    recover();

    pulse(2); wait_idle("R12");
    chk("R8", "final status", {bus_start, bus_stop}, 2'b01);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule